// File: doc/BRIEF.md
# Keyboard-Bus Host Command Transmitter

This block sends one command byte from a host to a keyboard over the two-wire, open-drain PS/2 bus. Both lines are pulled up outside the chip. The block only ever pulls a line low or lets it go; it never drives a line high. Host logic places a byte on `cmdByte` and pulses `startReq`. The block then runs the whole handover of the shared bus:

- It holds the clock line low for an inhibit period.
- It pulls data low as the start bit and lets go of clock.
- It shifts the byte out least significant bit first, followed by odd parity, changing data only after each falling edge of the clock that the device generates.
- It releases data for the stop bit.
- It looks for the device's acknowledge at the eleventh falling edge.

The inhibit period and both timeout limits are counted in microseconds. A parameterized prescaler derives the microsecond tick from the system clock. When the acknowledge is present, the block waits until both lines have returned high before it reports completion. When no acknowledge is present, it reports completion at once with a no-acknowledge flag, and the host may then expect the device's resend byte. When the device never starts clocking, or the transfer runs too long, the block releases both lines and raises a timeout flag.

Top module: `hostcmd_tx`

## Requirements
- R1: After reset, all outputs are low and neither bus line is pulled.
- R2: A start strobe accepted in idle pulls the clock line low for INHIBIT_US microseconds, each CLK_PER_US system clocks long, while data stays released.
- R3: When the clock line is released at the end of the inhibit period, the data line is pulled low in that same cycle (the start bit). It stays low until the first device falling clock edge.
- R4: The eight data bits leave least significant bit first. Each bit is placed on the line after a device falling clock edge and stays unchanged while the clock is high.
- R5: The ninth bit driven is odd parity: it is 1 when the byte holds an even number of ones.
- R6: Data is released (stop bit, line high) after the tenth device falling clock edge.
- R7: If data is low at the eleventh falling edge, `ackOk` is set. `done` then pulses for exactly one cycle only after both lines are seen high.
- R8: If data is high at the eleventh falling edge, `noAck` is set and `done` pulses at once. Exactly one of `ackOk` and `noAck` is high whenever `done` is high.
- R9: If no device falling edge arrives within CLK_WAIT_US after the start bit, `timedOut` is set, both lines are released, `busy` drops and `done` does not pulse. The next start clears the flag.
- R10: If the transfer does not finish within XFER_US of the first device falling edge, it ends as in R9.
- R11: `busy` rises only on an accepted start strobe and stays high until done or timeout. A start strobe while busy is ignored and leaves the byte in flight unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdByte | input | 8 | Command byte, captured on an accepted start |
| startReq | input | 1 | One-cycle start strobe |
| ps2ClkIn | input | 1 | Raw level of the bus clock line |
| ps2DataIn | input | 1 | Raw level of the bus data line |
| clkPullLow | output | 1 | 1 pulls the bus clock line low |
| dataPullLow | output | 1 | 1 pulls the bus data line low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a completed transfer |
| ackOk | output | 1 | Device acknowledged the last transfer |
| noAck | output | 1 | Device did not acknowledge the last transfer |
| timedOut | output | 1 | Last transfer ended on a timeout |

## Verification
The latencies are as follows:
- Every line change reaches the control three system clocks later: two synchronizer stages plus the edge register. A data bit therefore lands three cycles after a device falling edge. The bench samples it at the middle of the following high phase, well clear of any change.
- The clock pull lasts INHIBIT_US×CLK_PER_US plus one cycle, and the bench measures it within a one-cycle window.
- Each timeout flag appears one cycle after its microsecond count reaches its limit. The bench checks it inside a window wide enough for the prescaler phase.
- `done` is due three cycles after the last line returns high. The bench counts its pulses on falling system clock edges, so it can show both that no pulse appeared while the device still held data low and that exactly one appeared afterwards.

// File: rtl/hct_pkg.sv
package hct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INHIBIT,
    ST_REQUEST,
    ST_SHIFT,
    ST_SETTLE
  } ctlState_t;

  // Strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic loadByte;     // capture byte plus parity, clear edge count
    logic clearTimer;   // restart prescaler and microsecond count
    logic driveStart;   // pull data low for the start bit
    logic driveNext;    // present next frame bit on data
    logic releaseData;  // let data float high
    logic countEdge;    // one more device falling edge seen
  } dpStrobe_t;

endpackage

// File: rtl/hct_datapath.sv
module hct_datapath
  import hct_pkg::*;
#(
  parameter int CLK_PER_US  = 125,
  parameter int SYNC_STAGES = 2,
  parameter int TIMER_W     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [7:0]         cmdByte,
  input  logic               ps2ClkIn,
  input  logic               ps2DataIn,
  output logic               fallEdge,
  output logic               clkHigh,
  output logic               dataHigh,
  output logic [3:0]         edgeCount,
  output logic [TIMER_W-1:0] usCount,
  output logic               dataPullLow
);

  localparam int TICK_W = $clog2(CLK_PER_US + 1);

  logic [SYNC_STAGES-1:0] clkSync;
  logic [SYNC_STAGES-1:0] dataSync;
  logic                   clkPrev;
  logic [TICK_W-1:0]      tickCnt;
  logic                   usTick;
  logic [8:0]             frame;

  // Line synchronizers; idle bus reads high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync  <= '1;
      dataSync <= '1;
      clkPrev  <= 1'b1;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], ps2ClkIn};
      dataSync <= {dataSync[SYNC_STAGES-2:0], ps2DataIn};
      clkPrev  <= clkHigh;
    end
  end

  assign clkHigh  = clkSync[SYNC_STAGES-1];
  assign dataHigh = dataSync[SYNC_STAGES-1];
  assign fallEdge = clkPrev & ~clkHigh;

  // Microsecond prescaler and saturating count
  assign usTick = (tickCnt == TICK_W'(CLK_PER_US - 1));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearTimer) begin
      tickCnt <= '0;
      usCount <= '0;
    end else begin
      tickCnt <= usTick ? '0 : tickCnt + 1'b1;
      if (usTick && (usCount != '1)) usCount <= usCount + 1'b1;
    end
  end

  // Frame shifter: byte then odd parity, LSB leaves first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frame       <= '0;
      edgeCount   <= '0;
      dataPullLow <= 1'b0;
    end else begin
      if (strobe.loadByte) begin
        frame     <= {~^cmdByte, cmdByte};
        edgeCount <= '0;
      end else begin
        if (strobe.driveNext) frame <= {1'b0, frame[8:1]};
        if (strobe.countEdge) edgeCount <= edgeCount + 1'b1;
      end
      if (strobe.loadByte || strobe.releaseData) dataPullLow <= 1'b0;
      else if (strobe.driveStart)                dataPullLow <= 1'b1;
      else if (strobe.driveNext)                 dataPullLow <= ~frame[0];
    end
  end

endmodule

// File: rtl/hct_control.sv
module hct_control
  import hct_pkg::*;
#(
  parameter int INHIBIT_US  = 100,
  parameter int CLK_WAIT_US = 20000,
  parameter int XFER_US     = 2000,
  parameter int TIMER_W     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               fallEdge,
  input  logic               clkHigh,
  input  logic               dataHigh,
  input  logic [3:0]         edgeCount,
  input  logic [TIMER_W-1:0] usCount,
  output dpStrobe_t          strobe,
  output logic               clkPullLow,
  output logic               busy,
  output logic               done,
  output logic               ackOk,
  output logic               noAck,
  output logic               timedOut
);

  localparam logic [TIMER_W-1:0] INHIBIT_LIM = TIMER_W'(INHIBIT_US);
  localparam logic [TIMER_W-1:0] WAIT_LIM    = TIMER_W'(CLK_WAIT_US);
  localparam logic [TIMER_W-1:0] XFER_LIM    = TIMER_W'(XFER_US);

  ctlState_t state, nextState;
  logic accept, ackSeen, nackSeen, expire, complete;

  always_comb begin
    nextState = state;
    strobe    = '0;
    accept    = 1'b0;
    ackSeen   = 1'b0;
    nackSeen  = 1'b0;
    expire    = 1'b0;
    complete  = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        accept            = 1'b1;
        strobe.loadByte   = 1'b1;
        strobe.clearTimer = 1'b1;
        nextState         = ST_INHIBIT;
      end
      ST_INHIBIT: if (usCount >= INHIBIT_LIM) begin
        strobe.driveStart = 1'b1;
        strobe.clearTimer = 1'b1;
        nextState         = ST_REQUEST;
      end
      ST_REQUEST: begin
        if (fallEdge) begin
          strobe.driveNext  = 1'b1;
          strobe.countEdge  = 1'b1;
          strobe.clearTimer = 1'b1;
          nextState         = ST_SHIFT;
        end else if (usCount >= WAIT_LIM) begin
          expire = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (usCount >= XFER_LIM) begin
          expire = 1'b1;
        end else if (fallEdge) begin
          strobe.countEdge = 1'b1;
          if (edgeCount < 4'd9) begin
            strobe.driveNext = 1'b1;
          end else if (edgeCount == 4'd9) begin
            strobe.releaseData = 1'b1;
          end else if (!dataHigh) begin
            ackSeen   = 1'b1;
            nextState = ST_SETTLE;
          end else begin
            nackSeen  = 1'b1;
            complete  = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      ST_SETTLE: begin
        if (usCount >= XFER_LIM) begin
          expire = 1'b1;
        end else if (clkHigh && dataHigh) begin
          complete  = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (expire) begin
      strobe.releaseData = 1'b1;
      nextState          = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      clkPullLow <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      ackOk      <= 1'b0;
      noAck      <= 1'b0;
      timedOut   <= 1'b0;
    end else begin
      state      <= nextState;
      clkPullLow <= (nextState == ST_INHIBIT);
      busy       <= (nextState != ST_IDLE);
      done       <= complete;
      if (accept) begin
        ackOk    <= 1'b0;
        noAck    <= 1'b0;
        timedOut <= 1'b0;
      end else begin
        if (ackSeen)  ackOk    <= 1'b1;
        if (nackSeen) noAck    <= 1'b1;
        if (expire)   timedOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hostcmd_tx.sv
module hostcmd_tx
  import hct_pkg::*;
#(
  parameter int CLK_PER_US  = 125,
  parameter int INHIBIT_US  = 100,
  parameter int CLK_WAIT_US = 20000,
  parameter int XFER_US     = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cmdByte,
  input  logic       startReq,
  input  logic       ps2ClkIn,
  input  logic       ps2DataIn,
  output logic       clkPullLow,
  output logic       dataPullLow,
  output logic       busy,
  output logic       done,
  output logic       ackOk,
  output logic       noAck,
  output logic       timedOut
);

  localparam int MAX_US_A = (CLK_WAIT_US > XFER_US) ? CLK_WAIT_US : XFER_US;
  localparam int MAX_US   = (MAX_US_A > INHIBIT_US) ? MAX_US_A : INHIBIT_US;
  localparam int TIMER_W  = $clog2(MAX_US + 2);

  dpStrobe_t          strobe;
  logic               fallEdge, clkHigh, dataHigh;
  logic [3:0]         edgeCount;
  logic [TIMER_W-1:0] usCount;

  hct_datapath #(
    .CLK_PER_US (CLK_PER_US),
    .SYNC_STAGES(SYNC_STAGES),
    .TIMER_W    (TIMER_W)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdByte    (cmdByte),
    .ps2ClkIn   (ps2ClkIn),
    .ps2DataIn  (ps2DataIn),
    .fallEdge   (fallEdge),
    .clkHigh    (clkHigh),
    .dataHigh   (dataHigh),
    .edgeCount  (edgeCount),
    .usCount    (usCount),
    .dataPullLow(dataPullLow)
  );

  hct_control #(
    .INHIBIT_US (INHIBIT_US),
    .CLK_WAIT_US(CLK_WAIT_US),
    .XFER_US    (XFER_US),
    .TIMER_W    (TIMER_W)
  ) ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .fallEdge  (fallEdge),
    .clkHigh   (clkHigh),
    .dataHigh  (dataHigh),
    .edgeCount (edgeCount),
    .usCount   (usCount),
    .strobe    (strobe),
    .clkPullLow(clkPullLow),
    .busy      (busy),
    .done      (done),
    .ackOk     (ackOk),
    .noAck     (noAck),
    .timedOut  (timedOut)
  );

endmodule

// File: rtl/hct_checks.sv
module hct_checks (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic ps2ClkIn,
  input logic clkPullLow,
  input logic dataPullLow,
  input logic busy,
  input logic done,
  input logic ackOk,
  input logic noAck,
  input logic timedOut
);

  AST_INHIBIT_DATA_FREE: assert property (@(posedge clk) disable iff (!rstN) clkPullLow |-> !dataPullLow); // R2
  AST_DATA_HOLD_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN) (busy && ps2ClkIn && $past(ps2ClkIn) && $past(ps2ClkIn, 2) && $past(ps2ClkIn, 3)) |-> $stable(dataPullLow)); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R7
  AST_DONE_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN) done |-> ((ackOk ^ noAck) && !busy && !timedOut)); // R8
  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rstN) $rose(timedOut) |-> (!busy && !clkPullLow && !dataPullLow && !done)); // R9
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> $past(startReq)); // R11
  AST_CLK_PULL_BUSY: assert property (@(posedge clk) disable iff (!rstN) clkPullLow |-> busy); // R11

endmodule

bind hostcmd_tx hct_checks chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .ps2ClkIn   (ps2ClkIn),
  .clkPullLow (clkPullLow),
  .dataPullLow(dataPullLow),
  .busy       (busy),
  .done       (done),
  .ackOk      (ackOk),
  .noAck      (noAck),
  .timedOut   (timedOut)
);

// File: tb/hostcmd_tx_test.sv
module hostcmd_tx_test;

  localparam int CPU   = 4;
  localparam int INH   = 10;
  localparam int WAITL = 50;
  localparam int XFER  = 100;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic startReq = 1'b0;
  logic devClkLow = 1'b0;
  logic devDataLow = 1'b0;
  logic ps2Clk, ps2Data;
  logic clkPullLow, dataPullLow, busy, done, ackOk, noAck, timedOut;

  int passCount = 0;
  int failCount = 0;
  int doneSeen = 0;
  int doneRuns = 0;
  logic prevDone = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign ps2Clk  = ~(clkPullLow | devClkLow);
  assign ps2Data = ~(dataPullLow | devDataLow);

  hostcmd_tx #(
    .CLK_PER_US (CPU),
    .INHIBIT_US (INH),
    .CLK_WAIT_US(WAITL),
    .XFER_US    (XFER)
  ) uut (
    .clk        (clk),
    .rstN       (rstN),
    .cmdByte    (cmdByte),
    .startReq   (startReq),
    .ps2ClkIn   (ps2Clk),
    .ps2DataIn  (ps2Data),
    .clkPullLow (clkPullLow),
    .dataPullLow(dataPullLow),
    .busy       (busy),
    .done       (done),
    .ackOk      (ackOk),
    .noAck      (noAck),
    .timedOut   (timedOut)
  );

  always @(negedge clk) begin
    if (done) doneSeen++;
    if (done && prevDone) doneRuns++;
    prevDone = done;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    if (ok) passCount++;
    else begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", passCount, passCount + failCount);
  endtask

  task automatic startCmd(input logic [7:0] b);
    @(negedge clk);
    cmdByte  = b;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // Device side: wait for the request, then clock the frame in
  task automatic deviceRun(input int pulses, input bit giveAck, input int holdAfter,
                           output logic [10:0] got);
    int waitN = 0;
    got = '1;
    while (!(!clkPullLow && dataPullLow) && waitN < 2000) begin
      @(negedge clk);
      waitN++;
    end
    repeat (6) @(negedge clk);
    for (int i = 0; i < pulses; i++) begin
      devClkLow = 1'b1;
      repeat (HALF) @(negedge clk);
      devClkLow = 1'b0;
      repeat (HALF / 2) @(negedge clk);
      got[i] = ps2Data;
      if (i == 9 && giveAck) devDataLow = 1'b1;
      repeat (HALF / 2) @(negedge clk);
    end
    repeat (holdAfter) @(negedge clk);
    devDataLow = 1'b0;
  endtask

  task automatic waitDone(input int d0);
    int n = 0;
    while (doneSeen == d0 && n < 40) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic testReset();
    chk(!busy && !done && !ackOk && !noAck && !timedOut, "R1 flags after reset",
        {busy, done, ackOk, noAck, timedOut}, 0);
    chk(!clkPullLow && !dataPullLow, "R1 lines released after reset",
        {clkPullLow, dataPullLow}, 0);
  endtask

  task automatic sendAndCheck(input logic [7:0] b, input int hold);
    int inh = 0;
    bit dataFree = 1'b1;
    int d0;
    logic [10:0] got;
    startCmd(b);
    chk(busy, "R11 busy after start", busy, 1);
    while (clkPullLow && inh < 1000) begin
      if (dataPullLow) dataFree = 1'b0;
      inh++;
      @(negedge clk);
    end
    chk(inh >= 40 && inh <= 42, "R2 inhibit length", inh, 41);
    chk(dataFree, "R2 data released during inhibit", dataFree, 1);
    chk(dataPullLow, "R3 start bit as clock released", dataPullLow, 1);
    d0 = doneSeen;
    deviceRun(11, 1'b1, hold, got);
    chk(got[7:0] == b, "R4 data bits LSB first", got[7:0], b);
    chk(got[8] == ~^b, "R5 odd parity", got[8], ~^b);
    chk(got[9] == 1'b1, "R6 stop bit released", got[9], 1);
    if (hold > 0)
      chk(doneSeen == d0 && busy, "R7 done held while data low", doneSeen - d0, 0);
    waitDone(d0);
    chk(doneSeen == d0 + 1, "R7 one done pulse", doneSeen - d0, 1);
    chk(ackOk && !noAck && !timedOut, "R7 ack flags", {ackOk, noAck, timedOut}, 3'b100);
    chk(doneRuns == 0, "R7 done single cycle", doneRuns, 0);
    chk(!busy, "R11 busy cleared at done", busy, 0);
  endtask

  task automatic testNoAck(input logic [7:0] b);
    int d0;
    logic [10:0] got;
    d0 = doneSeen;
    startCmd(b);
    deviceRun(11, 1'b0, 0, got);
    repeat (4) @(negedge clk);
    chk(doneSeen == d0 + 1, "R8 done on missing ack", doneSeen - d0, 1);
    chk(noAck && !ackOk && !timedOut, "R8 noAck flags", {ackOk, noAck, timedOut}, 3'b010);
    chk(got[7:0] == b, "R4 data bits in noAck run", got[7:0], b);
  endtask

  task automatic testNoClock();
    int d0;
    int n = 0;
    d0 = doneSeen;
    startCmd(8'hFF);
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(n >= 230 && n <= 255, "R9 first-clock timeout timing", n, 242);
    chk(timedOut && !ackOk && !noAck, "R9 timeout flag", {ackOk, noAck, timedOut}, 3'b001);
    chk(!clkPullLow && !dataPullLow, "R9 lines released", {clkPullLow, dataPullLow}, 0);
    chk(doneSeen == d0, "R9 no done on timeout", doneSeen - d0, 0);
  endtask

  task automatic testStall();
    int d0;
    int n = 0;
    logic [10:0] got;
    d0 = doneSeen;
    startCmd(8'h12);
    deviceRun(4, 1'b0, 0, got);
    chk(busy && !timedOut, "R10 still busy after stall", {busy, timedOut}, 2'b10);
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(n >= 300 && n <= 420, "R10 transfer timeout timing", n, 339);
    chk(timedOut, "R10 timeout flag", timedOut, 1);
    chk(!clkPullLow && !dataPullLow, "R10 lines released", {clkPullLow, dataPullLow}, 0);
    chk(doneSeen == d0, "R10 no done on timeout", doneSeen - d0, 0);
  endtask

  task automatic testBusyIgnore();
    int d0;
    logic [10:0] got;
    d0 = doneSeen;
    startCmd(8'h3C);
    repeat (10) @(negedge clk);
    cmdByte  = 8'hC3;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy && clkPullLow, "R11 busy through second strobe", {busy, clkPullLow}, 2'b11);
    deviceRun(11, 1'b1, 0, got);
    chk(got[7:0] == 8'h3C, "R11 second start ignored", got[7:0], 8'h3C);
    waitDone(d0);
    chk(doneSeen == d0 + 1 && ackOk, "R11 single transfer completes", doneSeen - d0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    sendAndCheck(8'h5A, 0);
    repeat (20) @(negedge clk);
    sendAndCheck(8'h00, 25);
    repeat (20) @(negedge clk);
    sendAndCheck(8'hFF, 0);
    repeat (20) @(negedge clk);
    testNoAck(8'hED);
    repeat (20) @(negedge clk);
    testNoClock();
    repeat (20) @(negedge clk);
    sendAndCheck(8'hF4, 0);
    repeat (20) @(negedge clk);
    testStall();
    repeat (20) @(negedge clk);
    testBusyIgnore();
    repeat (10) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule